// File: doc/BRIEF.md
# Multiplexed Byte-Bus Transaction Master

This block runs single-byte transactions on a narrow bus where address and data share one set of eight lines. A request carries a 16-bit address, a direction, a write byte and a target index. The block sends the address as two bytes, each marked by its own latch-enable pulse. It then either drives the write byte or releases the lines for a read. Next it selects one target and asserts the read or write strobe. The transfer ends when the target pulls its active-low acknowledge line down, or when a cycle-count timeout expires.

The completion side gives a one-cycle done pulse, the captured byte and a timeout flag. Requests use a valid/ready handshake. Ready is low from acceptance until the done pulse, so only one transaction is ever in flight. The data lines are given as separate output, output-enable and input vectors. Pad logic outside the block joins them into a bidirectional bus. The acknowledge input is asynchronous and passes through a synchronizer before the sequencer uses it.

Top module: `mbus_master`

## Requirements
- R1: While reset is asserted, and whenever no transaction is running, every bit of bus_cs_n is high, bus_rd_n and bus_wr_n are high, both latch enables are low, bus_doe is low, req_ready is high and rsp_done is low.
- R2: A request is taken on a rising edge where req_valid and req_ready are both high. req_ready then stays low up to and including the cycle in which rsp_done is high, and is high again in the following cycle.
- R3: The address goes out first. For exactly PHASE_CYC cycles, bus_dout carries req_addr[7:0] with bus_ale_lo high. For the next exactly PHASE_CYC cycles, bus_dout carries req_addr[15:8] with bus_ale_hi high. bus_doe is high in both phases, and the two enables are never high together.
- R4: For a write (req_write = 1), from the end of the address phases until done, bus_doe is high and bus_dout equals the write byte. This holds through the setup, select and strobe phases.
- R5: For a read (req_write = 0), bus_doe is low from the end of the address phases until done.
- R6: In a transaction, only bus_cs_n[t] goes low, where t is the target index (bit 0 serves target 0, bit 1 serves target 1). At most one chip select is low at any time.
- R7: The chip select is asserted alone, with both strobes high, for exactly PHASE_CYC cycles. After that, bus_rd_n goes low for a read or bus_wr_n goes low for a write. The two strobes are never low together, and neither is ever low without a chip select.
- R8: bus_ack_n is active low and passes through SYNC_STAGES flops. The strobe stays asserted for at least PHASE_CYC cycles, and for at least SYNC_STAGES cycles after bus_ack_n is seen low.
- R9: When the acknowledge ends a transfer, the byte on bus_din is captured into rsp_rdata on the edge that ends the strobe. rsp_done is then high with rsp_timeout low.
- R10: If no acknowledge arrives, the strobe ends after exactly TMO_CYC cycles. The transaction then completes with rsp_timeout = 1 and rsp_rdata = 0.
- R11: In the done cycle, all chip selects and strobes are high. rsp_done lasts exactly one cycle. rsp_rdata and rsp_timeout keep their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Target address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Byte to write |
| req_tgt | input | TGT_W | Target index |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured byte (0 after timeout) |
| rsp_timeout | output | 1 | Transfer ended without acknowledge |
| bus_dout | output | DATA_W | Value driven onto the shared lines |
| bus_doe | output | 1 | Output enable for the shared lines |
| bus_din | input | DATA_W | Value sampled from the shared lines |
| bus_ale_lo | output | 1 | Latch enable for the low address byte |
| bus_ale_hi | output | 1 | Latch enable for the high address byte |
| bus_cs_n | output | NTGT | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ack_n | input | 1 | Active-low acknowledge from the target |

## Verification
The bench runs reads and writes to both targets, on addresses whose two bytes differ. An address whose byte halves were swapped or latched under the wrong enable would therefore show up. The modelled target answers with acknowledge delays of zero, one, five and ten strobe cycles. A zero delay shows whether the minimum phase length is enforced. The longer delays show whether the block waits for the synchronized acknowledge rather than a fixed count. Writes are read back to confirm the byte reached the target and that the data lines were driven in the right phases. One target is then made silent. This separates the timeout path (exact strobe length, flag set, data cleared) from the acknowledge path, and shows that a write abandoned by timeout does not change the target. A read after that confirms the block recovers.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALO,
      ST_AHI,
      ST_SETUP,
      ST_SELECT,
      ST_STROBE,
      ST_CLOSE
   } mbus_state_e;

endpackage

// File: rtl/mbus_ack_sync.sv
module mbus_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mbus_ack_sync: STAGES must be at least 2");
   end

   logic stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[0] <= 1'b1;
            else        stage_q[0] <= async_n;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[i] <= 1'b1;
            else        stage_q[i] <= stage_q[i-1];
         end
      end
   end

   assign sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/mbus_phase_ctl.sv
module mbus_phase_ctl
   import mbus_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 16,
   parameter int TGT_W     = 1,
   parameter int PHASE_CYC = 2,
   parameter int TMO_CYC   = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TGT_W-1:0]  req_tgt,
   input  logic              ack_low,
   input  logic [DATA_W-1:0] bus_din,
   output mbus_state_e       state,
   output logic [ADDR_W-1:0] addr_q,
   output logic              write_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [TGT_W-1:0]  tgt_q,
   output logic              req_ready,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_timeout
);

   localparam int PCW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
   localparam int TCW = $clog2(TMO_CYC + 1);
   localparam logic [PCW-1:0] PH_LAST  = PCW'(PHASE_CYC - 1);
   localparam logic [TCW-1:0] TMO_LAST = TCW'(TMO_CYC - 1);

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("mbus_phase_ctl: PHASE_CYC must be at least 1");
   end
   if (TMO_CYC <= PHASE_CYC) begin : g_bad_tmo
      $error("mbus_phase_ctl: TMO_CYC must exceed PHASE_CYC");
   end

   mbus_state_e    state_q;
   logic [PCW-1:0] ph_cnt_q;
   logic [TCW-1:0] tmo_cnt_q;
   logic           ph_end;

   assign ph_end    = (ph_cnt_q == PH_LAST);
   assign state     = state_q;
   assign req_ready = (state_q == ST_IDLE);
   assign rsp_done  = (state_q == ST_CLOSE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         ph_cnt_q    <= '0;
         tmo_cnt_q   <= '0;
         addr_q      <= '0;
         write_q     <= 1'b0;
         wdata_q     <= '0;
         tgt_q       <= '0;
         rsp_rdata   <= '0;
         rsp_timeout <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q   <= req_addr;
                  write_q  <= req_write;
                  wdata_q  <= req_wdata;
                  tgt_q    <= req_tgt;
                  ph_cnt_q <= '0;
                  state_q  <= ST_ALO;
               end
            end
            ST_ALO, ST_AHI, ST_SETUP, ST_SELECT: begin
               if (ph_end) begin
                  ph_cnt_q  <= '0;
                  tmo_cnt_q <= '0;
                  case (state_q)
                     ST_ALO:   state_q <= ST_AHI;
                     ST_AHI:   state_q <= ST_SETUP;
                     ST_SETUP: state_q <= ST_SELECT;
                     default:  state_q <= ST_STROBE;
                  endcase
               end else begin
                  ph_cnt_q <= ph_cnt_q + 1'b1;
               end
            end
            ST_STROBE: begin
               if (!ph_end) ph_cnt_q <= ph_cnt_q + 1'b1;
               if (ack_low && ph_end) begin
                  rsp_rdata   <= bus_din;
                  rsp_timeout <= 1'b0;
                  state_q     <= ST_CLOSE;
               end else if (tmo_cnt_q == TMO_LAST) begin
                  rsp_rdata   <= '0;
                  rsp_timeout <= 1'b1;
                  state_q     <= ST_CLOSE;
               end else begin
                  tmo_cnt_q <= tmo_cnt_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready); // R2
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> (!rsp_done && req_ready)); // R11
   AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsp_timeout) |-> rsp_done); // R10
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_done |-> $stable(rsp_rdata)); // R11

endmodule

// File: rtl/mbus_pin_drive.sv
module mbus_pin_drive
   import mbus_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int NTGT   = 2,
   parameter int TGT_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbus_state_e       state,
   input  logic [ADDR_W-1:0] addr_q,
   input  logic              write_q,
   input  logic [DATA_W-1:0] wdata_q,
   input  logic [TGT_W-1:0]  tgt_q,
   output logic [DATA_W-1:0] dout,
   output logic              doe,
   output logic              ale_lo,
   output logic              ale_hi,
   output logic [NTGT-1:0]   cs_n,
   output logic              rd_n,
   output logic              wr_n
);

   if (ADDR_W != 2 * DATA_W) begin : g_bad_addr
      $error("mbus_pin_drive: ADDR_W must be twice DATA_W");
   end
   if (NTGT < 1 || NTGT > (1 << TGT_W)) begin : g_bad_tgt
      $error("mbus_pin_drive: NTGT does not fit TGT_W");
   end

   logic selected;
   logic strobing;

   assign selected = (state == ST_SELECT) || (state == ST_STROBE);
   assign strobing = (state == ST_STROBE);
   assign ale_lo   = (state == ST_ALO);
   assign ale_hi   = (state == ST_AHI);
   assign rd_n     = !(strobing && !write_q);
   assign wr_n     = !(strobing && write_q);

   always_comb begin
      dout = '0;
      doe  = 1'b0;
      case (state)
         ST_ALO: begin
            dout = addr_q[DATA_W-1:0];
            doe  = 1'b1;
         end
         ST_AHI: begin
            dout = addr_q[ADDR_W-1:DATA_W];
            doe  = 1'b1;
         end
         ST_SETUP, ST_SELECT, ST_STROBE: begin
            if (write_q) begin
               dout = wdata_q;
               doe  = 1'b1;
            end
         end
         default: begin
            dout = '0;
            doe  = 1'b0;
         end
      endcase
   end

   for (genvar t = 0; t < NTGT; t++) begin : g_cs
      assign cs_n[t] = !(selected && (tgt_q == TGT_W'(t)));
   end

   AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1); // R6
   AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n || wr_n)); // R7
   AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n || !wr_n) |-> (cs_n != {NTGT{1'b1}})); // R7
   AST_CS_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) || $fell(wr_n)) |-> ($past(cs_n) != {NTGT{1'b1}})); // R7
   AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !doe); // R5
   AST_ALE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale_lo && ale_hi)); // R3

endmodule

// File: rtl/mbus_master.sv
module mbus_master
   import mbus_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 16,
   parameter int NTGT        = 2,
   parameter int PHASE_CYC   = 2,
   parameter int TMO_CYC     = 100000,
   parameter int SYNC_STAGES = 2,
   localparam int TGT_W      = (NTGT > 1) ? $clog2(NTGT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TGT_W-1:0]  req_tgt,
   output logic              rsp_done,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_timeout,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic [DATA_W-1:0] bus_din,
   output logic              bus_ale_lo,
   output logic              bus_ale_hi,
   output logic [NTGT-1:0]   bus_cs_n,
   output logic              bus_rd_n,
   output logic              bus_wr_n,
   input  logic              bus_ack_n
);

   mbus_state_e       state;
   logic [ADDR_W-1:0] addr_q;
   logic              write_q;
   logic [DATA_W-1:0] wdata_q;
   logic [TGT_W-1:0]  tgt_q;
   logic              ack_sync_n;

   mbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_n (bus_ack_n),
      .sync_n  (ack_sync_n)
   );

   mbus_phase_ctl #(
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .TGT_W     (TGT_W),
      .PHASE_CYC (PHASE_CYC),
      .TMO_CYC   (TMO_CYC)
   ) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_addr    (req_addr),
      .req_write   (req_write),
      .req_wdata   (req_wdata),
      .req_tgt     (req_tgt),
      .ack_low     (!ack_sync_n),
      .bus_din     (bus_din),
      .state       (state),
      .addr_q      (addr_q),
      .write_q     (write_q),
      .wdata_q     (wdata_q),
      .tgt_q       (tgt_q),
      .req_ready   (req_ready),
      .rsp_done    (rsp_done),
      .rsp_rdata   (rsp_rdata),
      .rsp_timeout (rsp_timeout)
   );

   mbus_pin_drive #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .NTGT   (NTGT),
      .TGT_W  (TGT_W)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .addr_q  (addr_q),
      .write_q (write_q),
      .wdata_q (wdata_q),
      .tgt_q   (tgt_q),
      .dout    (bus_dout),
      .doe     (bus_doe),
      .ale_lo  (bus_ale_lo),
      .ale_hi  (bus_ale_hi),
      .cs_n    (bus_cs_n),
      .rd_n    (bus_rd_n),
      .wr_n    (bus_wr_n)
   );

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (bus_rd_n && bus_wr_n && !bus_doe && (bus_cs_n == {NTGT{1'b1}}))); // R1

endmodule

// File: tb/sim_mbus_master.sv
module sim_mbus_master;

   localparam int P    = 3;
   localparam int TMO  = 40;
   localparam int SYNC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [7:0]  req_wdata = '0;
   logic        req_tgt = 1'b0;
   logic        rsp_done;
   logic [7:0]  rsp_rdata;
   logic        rsp_timeout;
   logic [7:0]  bus_dout;
   logic        bus_doe;
   logic [7:0]  bus_din = 8'hEE;
   logic        bus_ale_lo, bus_ale_hi;
   logic [1:0]  bus_cs_n;
   logic        bus_rd_n, bus_wr_n;
   logic        bus_ack_n = 1'b1;

   always #5 clk = ~clk;

   mbus_master #(.NTGT(2), .PHASE_CYC(P), .TMO_CYC(TMO), .SYNC_STAGES(SYNC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
      .req_tgt(req_tgt), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
      .rsp_timeout(rsp_timeout), .bus_dout(bus_dout), .bus_doe(bus_doe),
      .bus_din(bus_din), .bus_ale_lo(bus_ale_lo), .bus_ale_hi(bus_ale_hi),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
      .bus_ack_n(bus_ack_n)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   // ---------------- target model ----------------
   logic [7:0] dev_mem [2][16];
   bit         dev_ack_en [2];
   int         dev_dly = 0;
   int         dev_scnt = 0;
   logic [7:0] dev_lo = '0;

   always @(negedge clk) begin
      int t;
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) begin
            dev_mem[0][k] <= 8'(k * 7 + 8'h31);
            dev_mem[1][k] <= 8'(k * 13 + 8'h82);
         end
         bus_ack_n <= 1'b1;
         dev_scnt  <= 0;
      end else begin
         if (bus_ale_lo) dev_lo <= bus_dout;
         if (bus_cs_n != 2'b11 && (!bus_rd_n || !bus_wr_n)) begin
            t = bus_cs_n[0] ? 1 : 0;
            if (dev_ack_en[t] && dev_scnt >= dev_dly && bus_ack_n) begin
               bus_ack_n <= 1'b0;
               if (!bus_wr_n) dev_mem[t][dev_lo[3:0]] <= bus_dout;
               bus_din <= dev_mem[t][dev_lo[3:0]];
            end
            dev_scnt <= dev_scnt + 1;
         end else begin
            bus_ack_n <= 1'b1;
            dev_scnt  <= 0;
            bus_din   <= 8'hEE;
         end
      end
   end

   // ---------------- scoreboard ----------------
   typedef struct {
      logic [15:0] addr;
      logic        wr;
      logic [7:0]  wd;
      logic        tgt;
      logic [7:0]  rd;
      logic        tmo;
   } item_t;

   item_t      q[$];
   logic [7:0] ref_mem [2][16];

   task automatic do_op(input logic [15:0] a, input logic wr, input logic [7:0] wd,
                        input logic tg, input int dly);
      item_t it;
      it.addr = a; it.wr = wr; it.wd = wd; it.tgt = tg;
      it.tmo  = !dev_ack_en[tg];
      it.rd   = ref_mem[tg][a[3:0]];
      if (wr && !it.tmo) ref_mem[tg][a[3:0]] = wd;
      q.push_back(it);
      dev_dly = dly;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd; req_tgt = tg;
      @(negedge clk);
      req_valid = 1'b0;
      while (q.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   int alo_w = 0, ahi_w = 0, sel_w = 0, str_w = 0, ack_w = 0;
   bit seen_ahi = 0, saw_rd = 0, saw_wr = 0, hold_chk = 0;
   logic [7:0] lat_lo = '0, lat_hi = '0, hold_val = '0;
   logic       hold_tmo = 0;

   always @(negedge clk) begin
      item_t cur;
      bit strobe, csact;
      if (rst_n) begin
         if (hold_chk) begin
            chk("R11 rdata held", rsp_rdata, hold_val);
            chk("R11 timeout held", rsp_timeout, hold_tmo);
            chk("R11 done one cycle", rsp_done, 0);
            chk("R2 ready after done", req_ready, 1);
            hold_chk = 0;
         end
         if (bus_ale_lo) begin
            alo_w++; lat_lo = bus_dout;
            chk("R3 doe in low phase", bus_doe, 1);
            chk("R3 enables exclusive", bus_ale_hi, 0);
         end else if (alo_w != 0) begin
            chk("R3 low phase width", alo_w, P);
            alo_w = 0;
         end
         if (bus_ale_hi) begin
            ahi_w++; lat_hi = bus_dout;
            chk("R3 doe in high phase", bus_doe, 1);
         end else if (ahi_w != 0) begin
            chk("R3 high phase width", ahi_w, P);
            ahi_w = 0; seen_ahi = 1;
         end
         strobe = !bus_rd_n || !bus_wr_n;
         csact  = bus_cs_n != 2'b11;
         if (q.size() > 0) begin
            cur = q[0];
            if (seen_ahi && !rsp_done) begin
               if (cur.wr) begin
                  chk("R4 doe for write", bus_doe, 1);
                  chk("R4 write byte", bus_dout, cur.wd);
               end else begin
                  chk("R5 lines released", bus_doe, 0);
               end
            end
            if (csact) chk("R6 chip select", bus_cs_n, cur.tgt ? 2'b01 : 2'b10);
            if (csact && !strobe) sel_w++;
            if (strobe) begin
               str_w++;
               if (!bus_ack_n) ack_w++;
               if (!bus_rd_n) saw_rd = 1;
               if (!bus_wr_n) saw_wr = 1;
               chk("R7 strobes exclusive", bus_rd_n | bus_wr_n, 1);
            end
            if (rsp_done) begin
               void'(q.pop_front());
               chk("R2 ready low at done", req_ready, 0);
               chk("R3 address", {lat_hi, lat_lo}, cur.addr);
               chk("R7 select alone width", sel_w, P);
               chk("R7 write strobe used", saw_wr, cur.wr);
               chk("R7 read strobe used", saw_rd, !cur.wr);
               chk("R11 selects idle at done", bus_cs_n, 2'b11);
               chk("R11 strobes idle at done", bus_rd_n & bus_wr_n, 1);
               if (cur.tmo) begin
                  chk("R10 timeout flag", rsp_timeout, 1);
                  chk("R10 strobe length", str_w, TMO);
                  chk("R10 data cleared", rsp_rdata, 0);
               end else begin
                  chk("R9 no timeout", rsp_timeout, 0);
                  chk("R8 min strobe", int'(str_w >= P), 1);
                  chk("R8 sync latency", int'(ack_w >= SYNC), 1);
                  if (!cur.wr) chk("R9 read data", rsp_rdata, cur.rd);
               end
               hold_chk = 1; hold_val = rsp_rdata; hold_tmo = rsp_timeout;
               sel_w = 0; str_w = 0; ack_w = 0;
               seen_ahi = 0; saw_rd = 0; saw_wr = 0;
            end
         end
      end
   end

   initial begin
      for (int k = 0; k < 16; k++) begin
         ref_mem[0][k] = 8'(k * 7 + 8'h31);
         ref_mem[1][k] = 8'(k * 13 + 8'h82);
      end
      dev_ack_en[0] = 1; dev_ack_en[1] = 1;
      repeat (3) @(negedge clk);
      chk("R1 selects in reset", bus_cs_n, 2'b11);
      chk("R1 strobes in reset", {bus_rd_n, bus_wr_n}, 2'b11);
      chk("R1 enables in reset", {bus_ale_lo, bus_ale_hi, bus_doe}, 0);
      chk("R1 ready in reset", req_ready, 1);
      chk("R1 done in reset", rsp_done, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {bus_cs_n, bus_rd_n, bus_wr_n, bus_doe}, 5'b11110);

      do_op(16'h1234, 0, 8'h00, 0, 0);   // immediate ack: minimum phase
      do_op(16'h1235, 1, 8'h5A, 0, 1);
      do_op(16'h1235, 0, 8'h00, 0, 2);   // read back
      do_op(16'hABC3, 1, 8'hC3, 1, 5);
      do_op(16'hABC3, 0, 8'h00, 1, 10);
      do_op(16'h00F0, 0, 8'h00, 1, 3);
      dev_ack_en[1] = 0;
      do_op(16'h0001, 0, 8'h00, 1, 0);   // R10 timeout on read
      do_op(16'h0002, 1, 8'h77, 1, 0);   // R10 timeout on write
      dev_ack_en[1] = 1;
      do_op(16'h0002, 0, 8'h00, 1, 1);   // write did not land
      do_op(16'hFFFF, 0, 8'h00, 0, 4);
      do_op(16'h8001, 1, 8'h0F, 0, 0);
      do_op(16'h7F01, 0, 8'h00, 0, 0);   // R3 high byte differs, same low nibble
      report();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hang expected completion");
         report();
      end
   end

endmodule